// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital control core of a dual-slope integrating analog-to-digital converter. It runs from a fast oscillator clock, which it divides into a slower count clock. Each conversion walks through three phases. Auto-zero nulls the analog chain. Signal integrate runs for a fixed number of counts. Reference deintegrate then drives the integrator back toward zero. Four registered switch-control outputs select which analog path is active. A single comparator input reports the sign of the integrator output.

The number of counts spent in deintegrate is the reading, held in cascaded BCD decades. The block never lets deintegrate run longer than a full-scale budget, and auto-zero absorbs whatever part of that budget deintegrate did not use. Every conversion therefore takes the same number of counts whatever the input level. When deintegrate ends, the BCD value, the input polarity and an overrange flag are latched for a display stage, and a one-cycle strobe marks the update.

Top module: `dsc_sequencer`

## Requirements
- R1: While reset is low, and right after it is released, `sw_az_o` is 1, the other three switch outputs are 0, `rd_bcd_o` is zero, and `rd_neg_o`, `rd_over_o` and `rd_valid_o` are 0.
- R2: A count boundary falls on every PRESCALE-th rising edge of `clk_i` after reset release. The switch outputs change only on those edges.
- R3: Exactly one of `sw_az_o`, `sw_int_o`, `sw_ref_up_o`, `sw_ref_dn_o` is 1 in every cycle.
- R4: Signal integrate always follows auto-zero and lasts exactly INT_COUNTS counts.
- R5: At the boundary that ends integrate, the comparator is sampled (`cmp_i` = 1 means the integrator output is above zero). A low comparator marks the input negative and selects `sw_ref_up_o` for deintegrate. A high comparator marks it positive and selects `sw_ref_dn_o`.
- R6: At each count boundary in deintegrate, the comparator is sampled. When it shows the sense opposite to the one sampled at the end of integrate, the phase ends. The reading is then the number of deintegrate counts completed before that boundary. The reading appears on `rd_bcd_o` as BCD, with the units digit in bits 3:0, tens in 7:4, and so on. Each digit is 0 to 9.
- R7: Suppose DE_MAX counts have been taken and the comparator has still not crossed. Then deintegrate ends at that boundary, and the block latches `rd_over_o` = 1 with `rd_bcd_o` all zero. A crossing seen at that same boundary takes priority and gives the numeric reading DE_MAX-1.
- R8: Integrate starts every CYCLE_COUNTS counts, and auto-zero fills the rest of each conversion. The first auto-zero after reset lasts CYCLE_COUNTS-INT_COUNTS-DE_MAX counts.
- R9: `rd_bcd_o`, `rd_neg_o` and `rd_over_o` update only on the edge that ends deintegrate, which is also the edge that re-enters auto-zero. `rd_valid_o` is 1 for exactly the one clock cycle that follows that edge.
- R10: The polarity flag `rd_neg_o` follows the sign sampled at the end of integrate, even when the reading is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Comparator, 1 when the integrator output is above zero |
| sw_az_o | output | 1 | Auto-zero switch enable |
| sw_int_o | output | 1 | Signal integrate switch enable |
| sw_ref_up_o | output | 1 | Deintegrate with reference that ramps the integrator upward |
| sw_ref_dn_o | output | 1 | Deintegrate with reference that ramps the integrator downward |
| rd_bcd_o | output | 4*DIGITS | Latched reading, BCD, units in the low nibble |
| rd_neg_o | output | 1 | Latched polarity, 1 for a negative input |
| rd_over_o | output | 1 | Latched overrange flag |
| rd_valid_o | output | 1 | One-cycle strobe on a new latched result |

## Verification
The bench builds the block with PRESCALE 4, INT_COUNTS 50, DE_MAX 120 and CYCLE_COUNTS 200. These values give a three-digit counter and an 800-cycle conversion. Within a short run, the stimulus can then reach the decade carries at 9 to 10 and at 99 to 100, the largest numeric reading of 119, and the exact overrange boundary from both polarities. The integrator is modelled with a reference step of 100 units, so the input levels can land just below, exactly on and just above a count boundary. This exercises the comparator at zero and signed zero readings.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    // Switch-control word; exactly one bit is set at any time.
    typedef struct packed {
        logic az;
        logic integ;
        logic ref_up;
        logic ref_dn;
    } dsc_sw_t;

    typedef enum logic [1:0] {
        PH_AZ  = 2'd0,
        PH_INT = 2'd1,
        PH_DE  = 2'd2
    } dsc_phase_e;

    localparam dsc_sw_t SW_AZ  = 4'b1000;
    localparam dsc_sw_t SW_INT = 4'b0100;
    localparam dsc_sw_t SW_UP  = 4'b0010;
    localparam dsc_sw_t SW_DN  = 4'b0001;

    // Number of decimal digits needed to show a non-negative value.
    function automatic int dec_digits(input int value);
        int n;
        int v;
        n = 1;
        v = value;
        for (int i = 0; i < 10; i++) begin
            if (v >= 10) begin
                v = v / 10;
                n = n + 1;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/dsc_prescaler.sv
module dsc_prescaler #(
    parameter int unsigned PRESCALE = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);

    localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    generate
        if (PRESCALE == 1) begin : g_pass
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] div_d, div_q;

            always_comb begin
                div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_d;
                end
            end

            assign tick_o = (div_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/dsc_bcd_counter.sv
module dsc_bcd_counter #(
    parameter int unsigned DIGITS = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  clr_i,
    input  logic                  inc_i,
    output logic [4*DIGITS-1:0]   bcd_o
);

    logic [DIGITS-1:0] carry;

    assign carry[0] = inc_i;

    generate
        for (genvar g = 0; g < DIGITS; g++) begin : g_dig
            logic [3:0] dig_d, dig_q;
            logic       at_nine;

            assign at_nine = (dig_q == 4'd9);

            if (g < DIGITS - 1) begin : g_carry
                assign carry[g+1] = carry[g] & at_nine;
            end

            always_comb begin
                dig_d = dig_q;
                if (clr_i) begin
                    dig_d = 4'd0;
                end else if (carry[g]) begin
                    dig_d = at_nine ? 4'd0 : dig_q + 4'd1;
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    dig_q <= 4'd0;
                end else begin
                    dig_q <= dig_d;
                end
            end

            assign bcd_o[4*g +: 4] = dig_q;
        end
    endgenerate

endmodule

// File: rtl/dsc_phase_ctrl.sv
module dsc_phase_ctrl
    import dsc_pkg::*;
#(
    parameter int unsigned INT_COUNTS   = 1000,
    parameter int unsigned DE_MAX       = 2000,
    parameter int unsigned CYCLE_COUNTS = 4000
) (
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    tick_i,
    input  logic    cmp_i,
    output dsc_sw_t sw_o,
    output logic    neg_o,
    output logic    step_o,
    output logic    done_o,
    output logic    over_o
);

    localparam int unsigned TW = $clog2(CYCLE_COUNTS);
    localparam logic [TW-1:0] INT_LAST = TW'(INT_COUNTS - 1);
    localparam logic [TW-1:0] DE_LAST  = TW'(INT_COUNTS + DE_MAX - 1);
    localparam logic [TW-1:0] CYC_LAST = TW'(CYCLE_COUNTS - 1);
    localparam logic [TW-1:0] RST_POS  = TW'(INT_COUNTS + DE_MAX);

    typedef struct packed {
        dsc_phase_e    phase;
        logic [TW-1:0] pos;
        logic          neg;
        dsc_sw_t       sw;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  crossed;

    always_comb begin
        s_d     = s_q;
        step_o  = 1'b0;
        done_o  = 1'b0;
        over_o  = 1'b0;
        crossed = (cmp_i == s_q.neg);
        if (tick_i) begin
            s_d.pos = (s_q.pos == CYC_LAST) ? '0 : s_q.pos + 1'b1;
            unique case (s_q.phase)
                PH_AZ: begin
                    if (s_q.pos == CYC_LAST) begin
                        s_d.phase = PH_INT;
                        s_d.sw    = SW_INT;
                    end
                end
                PH_INT: begin
                    if (s_q.pos == INT_LAST) begin
                        s_d.neg   = ~cmp_i;
                        s_d.phase = PH_DE;
                        s_d.sw    = cmp_i ? SW_DN : SW_UP;
                    end
                end
                PH_DE: begin
                    if (crossed) begin
                        done_o = 1'b1;
                    end else if (s_q.pos == DE_LAST) begin
                        done_o = 1'b1;
                        over_o = 1'b1;
                    end else begin
                        step_o = 1'b1;
                    end
                    if (done_o) begin
                        s_d.phase = PH_AZ;
                        s_d.sw    = SW_AZ;
                    end
                end
                default: begin
                    s_d.phase = PH_AZ;
                    s_d.sw    = SW_AZ;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.phase <= PH_AZ;
            s_q.pos   <= RST_POS;
            s_q.neg   <= 1'b0;
            s_q.sw    <= SW_AZ;
        end else begin
            s_q <= s_d;
        end
    end

    assign sw_o  = s_q.sw;
    assign neg_o = s_q.neg;

endmodule

// File: rtl/dsc_sequencer.sv
module dsc_sequencer
    import dsc_pkg::*;
#(
    parameter int unsigned PRESCALE     = 4,
    parameter int unsigned INT_COUNTS   = 1000,
    parameter int unsigned DE_MAX       = 2000,
    parameter int unsigned CYCLE_COUNTS = 4000,
    localparam int unsigned DIGITS      = dsc_pkg::dec_digits(int'(DE_MAX) - 1),
    localparam int unsigned BCD_W       = 4 * DIGITS
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cmp_i,
    output logic             sw_az_o,
    output logic             sw_int_o,
    output logic             sw_ref_up_o,
    output logic             sw_ref_dn_o,
    output logic [BCD_W-1:0] rd_bcd_o,
    output logic             rd_neg_o,
    output logic             rd_over_o,
    output logic             rd_valid_o
);

    typedef struct packed {
        logic [BCD_W-1:0] bcd;
        logic             neg;
        logic             over;
        logic             valid;
    } latch_t;

    logic             tick;
    dsc_sw_t          sw;
    logic             ctrl_neg;
    logic             de_step;
    logic             de_done;
    logic             de_over;
    logic [BCD_W-1:0] cnt_bcd;
    latch_t           lat_d, lat_q;

    dsc_prescaler #(
        .PRESCALE (PRESCALE)
    ) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    dsc_phase_ctrl #(
        .INT_COUNTS   (INT_COUNTS),
        .DE_MAX       (DE_MAX),
        .CYCLE_COUNTS (CYCLE_COUNTS)
    ) u_ctrl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick),
        .cmp_i  (cmp_i),
        .sw_o   (sw),
        .neg_o  (ctrl_neg),
        .step_o (de_step),
        .done_o (de_done),
        .over_o (de_over)
    );

    dsc_bcd_counter #(
        .DIGITS (DIGITS)
    ) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (de_done),
        .inc_i  (de_step),
        .bcd_o  (cnt_bcd)
    );

    always_comb begin
        lat_d       = lat_q;
        lat_d.valid = 1'b0;
        if (de_done) begin
            lat_d.bcd   = de_over ? '0 : cnt_bcd;
            lat_d.neg   = ctrl_neg;
            lat_d.over  = de_over;
            lat_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign sw_az_o     = sw.az;
    assign sw_int_o    = sw.integ;
    assign sw_ref_up_o = sw.ref_up;
    assign sw_ref_dn_o = sw.ref_dn;
    assign rd_bcd_o    = lat_q.bcd;
    assign rd_neg_o    = lat_q.neg;
    assign rd_over_o   = lat_q.over;
    assign rd_valid_o  = lat_q.valid;

endmodule

// File: rtl/dsc_sequencer_chk.sv
module dsc_sequencer_chk #(
    parameter int unsigned PRESCALE     = 4,
    parameter int unsigned INT_COUNTS   = 1000,
    parameter int unsigned DE_MAX       = 2000,
    parameter int unsigned CYCLE_COUNTS = 4000,
    parameter int unsigned BCD_W        = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic             cmp_i,
    input logic             sw_az_i,
    input logic             sw_int_i,
    input logic             sw_up_i,
    input logic             sw_dn_i,
    input logic [BCD_W-1:0] rd_bcd_i,
    input logic             rd_over_i,
    input logic             rd_valid_i
);

    int   int_ticks;
    int   de_ticks;
    int   per_cnt;
    logic seen_int;
    logic int_prev;
    logic int_rise;

    assign int_rise = sw_int_i & ~int_prev;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            int_ticks <= 0;
            de_ticks  <= 0;
            per_cnt   <= 0;
            seen_int  <= 1'b0;
            int_prev  <= 1'b0;
        end else begin
            int_prev <= sw_int_i;
            if (!sw_int_i) int_ticks <= 0;
            else if (tick_i) int_ticks <= int_ticks + 1;
            if (!(sw_up_i || sw_dn_i)) de_ticks <= 0;
            else if (tick_i) de_ticks <= de_ticks + 1;
            if (int_rise) begin
                per_cnt  <= 1;
                seen_int <= 1'b1;
            end else begin
                per_cnt <= per_cnt + 1;
            end
        end
    end

    AST_SW_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({sw_az_i, sw_int_i, sw_up_i, sw_dn_i}) == 1); // R3

    AST_SW_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable({sw_az_i, sw_int_i, sw_up_i, sw_dn_i})); // R2

    AST_INT_AFTER_AZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sw_int_i) |-> $past(sw_az_i)); // R4

    AST_INT_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sw_int_i) |-> int_ticks == int'(INT_COUNTS)); // R4

    AST_UP_ON_LOW_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sw_up_i) |-> !$past(cmp_i)); // R5

    AST_DN_ON_HIGH_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sw_dn_i) |-> $past(cmp_i)); // R5

    AST_UP_ENDS_ON_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sw_up_i) |-> ($past(cmp_i) || $past(de_ticks) == int'(DE_MAX) - 1)); // R6

    AST_DN_ENDS_ON_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sw_dn_i) |-> (!$past(cmp_i) || $past(de_ticks) == int'(DE_MAX) - 1)); // R6

    AST_DE_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((sw_up_i || sw_dn_i) && tick_i) |-> de_ticks < int'(DE_MAX)); // R7

    AST_OVER_BLANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_over_i |-> rd_bcd_i == '0); // R7

    AST_CONV_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int_rise && seen_int) |-> per_cnt == int'(CYCLE_COUNTS * PRESCALE)); // R8

    AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_i |=> !rd_valid_i); // R9

    AST_VALID_AT_DE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_i |-> (sw_az_i && $past(sw_up_i || sw_dn_i))); // R9

endmodule

bind dsc_sequencer dsc_sequencer_chk #(
    .PRESCALE     (PRESCALE),
    .INT_COUNTS   (INT_COUNTS),
    .DE_MAX       (DE_MAX),
    .CYCLE_COUNTS (CYCLE_COUNTS),
    .BCD_W        (BCD_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .cmp_i      (cmp_i),
    .sw_az_i    (sw_az_o),
    .sw_int_i   (sw_int_o),
    .sw_up_i    (sw_ref_up_o),
    .sw_dn_i    (sw_ref_dn_o),
    .rd_bcd_i   (rd_bcd_o),
    .rd_over_i  (rd_over_o),
    .rd_valid_i (rd_valid_o)
);

// File: tb/tb_dsc_sequencer.sv
`timescale 1ns/1ps
module tb_dsc_sequencer;

    localparam int P    = 4;
    localparam int NI   = 50;
    localparam int NDE  = 120;
    localparam int NC   = 200;
    localparam int DIG  = 3;
    localparam int BW   = 4 * DIG;
    localparam int VREF = 100;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmp   = 1'b0;
    logic          sw_az, sw_int, sw_up, sw_dn;
    logic [BW-1:0] rd_bcd;
    logic          rd_neg, rd_over, rd_valid;

    always #4 clk = ~clk;

    dsc_sequencer #(
        .PRESCALE     (P),
        .INT_COUNTS   (NI),
        .DE_MAX       (NDE),
        .CYCLE_COUNTS (NC)
    ) dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cmp_i       (cmp),
        .sw_az_o     (sw_az),
        .sw_int_o    (sw_int),
        .sw_ref_up_o (sw_up),
        .sw_ref_dn_o (sw_dn),
        .rd_bcd_o    (rd_bcd),
        .rd_neg_o    (rd_neg),
        .rd_over_o   (rd_over),
        .rd_valid_o  (rd_valid)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int bcd_val(input logic [BW-1:0] b);
        int v = 0;
        for (int i = DIG - 1; i >= 0; i--) v = v * 10 + int'(b[4*i +: 4]);
        return v;
    endfunction

    function automatic bit bcd_legal(input logic [BW-1:0] b);
        bit ok = 1'b1;
        for (int i = 0; i < DIG; i++) if (b[4*i +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    // ---------------- behavioural reference model ----------------
    // phase codes: 8 = auto-zero, 4 = integrate, 2 = ramp up, 1 = ramp down
    int m_ph, m_pre, m_pos, m_cnt, m_rd;
    bit m_neg, m_rneg, m_rover, m_valid;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 8; m_pre = 0; m_pos = NI + NDE; m_cnt = 0; m_neg = 0;
            m_rd = 0; m_rneg = 0; m_rover = 0; m_valid = 0;
        end else begin
            bit tick;
            tick    = (m_pre == P - 1);
            m_pre   = tick ? 0 : m_pre + 1;
            m_valid = 0;
            if (tick) begin
                if (m_ph == 8) begin
                    if (m_pos == NC - 1) m_ph = 4;
                end else if (m_ph == 4) begin
                    if (m_pos == NI - 1) begin
                        m_neg = !cmp;
                        m_ph  = m_neg ? 2 : 1;
                    end
                end else begin
                    if (cmp == m_neg) begin
                        m_rd = m_cnt; m_rover = 0; m_rneg = m_neg; m_valid = 1;
                        m_cnt = 0; m_ph = 8;
                    end else if (m_cnt == NDE - 1) begin
                        m_rd = 0; m_rover = 1; m_rneg = m_neg; m_valid = 1;
                        m_cnt = 0; m_ph = 8;
                    end else begin
                        m_cnt++;
                    end
                end
                m_pos = (m_pos == NC - 1) ? 0 : m_pos + 1;
            end
        end
    end

    // ---------------- integrator, per-cycle compare, timing probes ----------------
    longint acc = 0;
    int     vin = 0;
    int     edges = 0;
    int     last_rise = -1;
    bit     prev_int = 1'b0;
    int     prev_sw = 8;

    always @(negedge clk) begin
        if (rst_n) begin
            int sw_now;
            edges++;
            sw_now = {28'd0, sw_az, sw_int, sw_up, sw_dn};
            chk(sw_now == m_ph, "R3", "switch pattern", sw_now, m_ph);
            chk(rd_valid == m_valid, "R9", "valid strobe", rd_valid, m_valid);
            chk(bcd_val(rd_bcd) == m_rd, "R6", "latched reading", bcd_val(rd_bcd), m_rd);
            chk(bcd_legal(rd_bcd), "R6", "BCD digit range", rd_bcd, 0);
            chk(rd_neg == m_rneg, "R5", "latched polarity", rd_neg, m_rneg);
            chk(rd_over == m_rover, "R7", "latched overrange", rd_over, m_rover);
            if (sw_now != prev_sw)
                chk((edges % P) == 0, "R2", "switch change off a count boundary", edges % P, 0);
            prev_sw = sw_now;
            if (sw_int && !prev_int) begin
                if (last_rise < 0)
                    chk(edges == (NC - NI - NDE) * P, "R8", "first auto-zero length",
                        edges, (NC - NI - NDE) * P);
                else
                    chk(edges - last_rise == NC * P, "R8", "conversion length",
                        edges - last_rise, NC * P);
                last_rise = edges;
            end
            if (!sw_int && prev_int)
                chk(edges - last_rise == NI * P, "R4", "integrate length",
                    edges - last_rise, NI * P);
            prev_int = sw_int;
            if (m_pre == P - 1) begin
                if (sw_az) acc = 0;
                else if (sw_int) acc = acc + vin;
                else if (sw_up) acc = acc + VREF;
                else if (sw_dn) acc = acc - VREF;
                cmp = (acc > 0);
            end
        end
    end

    // ideal reading from the requirements for a constant input level
    task automatic ideal(input int v, output int rd, output bit neg, output bit over);
        longint s = longint'(v) * NI;
        longint q;
        if (s > 0) begin
            neg = 1'b0;
            q = (s + VREF - 1) / VREF - 1;
        end else begin
            neg = 1'b1;
            q = (-s) / VREF;
        end
        over = (q >= NDE);
        rd = over ? 0 : int'(q);
    endtask

    initial begin
        int vals[$];
        int e_rd;
        bit e_neg, e_over;
        // 203:101 carry, -57:28 neg, 1:0 pos, -1:0 neg (R10), 21:10 carry, 20:9,
        // 199:99, 201:100, 239:119 max, 240:119 exact cross, 241:over,
        // -239:119, -240:over, -250:over
        vals = '{203, -57, 1, -1, 21, 20, 199, 201, 239, 240, 241, -239, -240, -250};
        vin = vals[0];
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({sw_az, sw_int, sw_up, sw_dn} == 4'b1000, "R1", "reset switches",
            {sw_az, sw_int, sw_up, sw_dn}, 8);
        chk(rd_bcd == '0 && !rd_neg && !rd_over && !rd_valid, "R1", "reset result",
            {rd_bcd, rd_neg, rd_over, rd_valid}, 0);
        #1 rst_n = 1'b1;
        foreach (vals[i]) begin
            vin = vals[i];
            @(negedge clk);
            while (!rd_valid) @(negedge clk);
            ideal(vals[i], e_rd, e_neg, e_over);
            chk(bcd_val(rd_bcd) == e_rd, "R6", $sformatf("reading for level %0d", vals[i]),
                bcd_val(rd_bcd), e_rd);
            chk(rd_over == e_over, "R7", $sformatf("overrange for level %0d", vals[i]),
                rd_over, e_over);
            if (e_rd == 0 && !e_over)
                chk(rd_neg == e_neg, "R10", $sformatf("polarity at zero, level %0d", vals[i]),
                    rd_neg, e_neg);
            else
                chk(rd_neg == e_neg, "R5", $sformatf("polarity for level %0d", vals[i]),
                    rd_neg, e_neg);
            chk(sw_az, "R9", "auto-zero during strobe", sw_az, 1);
        end
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule